// File: doc/BRIEF.md
# Cache Line Fill Controller

This block runs the read-allocate sequence of a four-way set-associative cache with 32-byte lines. When a miss is accepted, it picks the way to replace. It then asks the memory side for one aligned burst of four 64-bit beats, and the beat holding the requested quadword comes first. Each beat is written into the data array as it arrives, and the first beat is also forwarded to the requester at once. Once the fourth beat is written, the controller issues a single state update for the line.

The surrounding cache presents the valid and dirty bits of all four ways at the missed index, together with the current tag and the 256-bit contents of the way that may be replaced. If the chosen way holds modified data, that data is copied into a one-entry writeback buffer in the same step that accepts the miss. The copy is therefore safe before the first new beat overwrites the line. The buffer is then drained by an external agent while the fill goes on.

Top module: `line_fill_ctrl`

## Requirements
- R1: When at least one way at the index is invalid (way_valid bit 0), the fill targets the invalid way with the lowest number, as seen on wr_way and upd_way.
- R2: When all four ways are valid, the way comes from the low two bits of an 8-bit maximal-length LFSR. The LFSR is seeded to 1 at reset and steps every clock, so every way gets chosen across successive fills.
- R3: One cycle after a miss is accepted, req_valid is high. req_addr is the miss address with its five low bits cleared, and req_qw is miss_addr[4:3]. req_valid and req_addr stay unchanged until req_ready is seen.
- R4: Beat k of the burst (k = 0..3) is written at quadword index req_qw XOR k, with wr_index = miss_addr[10:5] and wr_data equal to the beat. The first two beats therefore fill one half of the line (same bit 1) and the last two fill the other half.
- R5: fwd_valid is high only in the cycle of the first beat, and fwd_data equals that beat. It stays low for the other three beats.
- R6: upd_valid pulses once, in the cycle of the fourth beat, with upd_way equal to the filled way and upd_index equal to the line index. It is never high earlier in the fill.
- R7: If the chosen way is valid and dirty, wb_valid rises one cycle after acceptance, with wb_data, wb_tag, wb_index and wb_way holding the victim's line, tag, index and way. A clean or invalid victim does not load the buffer.
- R8: Once loaded, the writeback buffer holds its valid flag and its contents unchanged until a cycle with wb_ack high. wb_valid is low in the cycle after that.
- R9: busy is high while a fill is in progress or wb_valid is high. A miss presented while busy is ignored, so req_valid stays low.
- R10: After reset, busy, req_valid, wr_en, fwd_valid, upd_valid and wb_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A read miss is presented |
| miss_addr | input | ADDR_W | Byte address of the missed access |
| way_valid | input | 4 | Valid bits of the four ways at the missed index |
| way_dirty | input | 4 | Modified bits of the four ways at the missed index |
| victim_tag | input | ADDR_W-IDX_W-5 | Tag of the way that would be replaced |
| victim_line | input | 256 | Current contents of the way that would be replaced |
| busy | output | 1 | New misses are not accepted |
| req_valid | output | 1 | Burst request pending |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | ADDR_W | Line-aligned burst address |
| req_qw | output | 2 | Quadword to deliver first |
| beat_valid | input | 1 | A 64-bit beat is on beat_data |
| beat_data | input | 64 | Burst beat |
| beat_ready | output | 1 | Beats are being taken |
| wr_en | output | 1 | Write one quadword into the data array |
| wr_way | output | 2 | Way being written |
| wr_index | output | IDX_W | Set index being written |
| wr_qw | output | 2 | Quadword slot within the line |
| wr_data | output | 64 | Quadword written |
| fwd_valid | output | 1 | Requested quadword forwarded |
| fwd_data | output | 64 | Forwarded quadword |
| upd_valid | output | 1 | Mark the filled line valid and clean |
| upd_way | output | 2 | Way whose state is updated |
| upd_index | output | IDX_W | Index whose state is updated |
| wb_valid | output | 1 | Writeback buffer holds a modified line |
| wb_tag | output | ADDR_W-IDX_W-5 | Tag of the buffered line |
| wb_index | output | IDX_W | Index of the buffered line |
| wb_way | output | 2 | Way the buffered line came from |
| wb_data | output | 256 | Buffered line contents |
| wb_ack | input | 1 | Buffer has been drained |

## Verification
The drain acknowledge of the writeback buffer can land in the same cycle as the fourth beat and its state update. The fill end and the buffer release then both clear their part of busy on one edge. The sweep provokes this by raising wb_ack together with the last beat for half of the dirty-victim fills. In the following cycle it expects upd_valid to have pulsed once, wb_valid to be low and busy to be low, so that the next miss is accepted at once. Fills that end without the acknowledge are instead checked to stay busy, ignore a new miss and keep the buffer stable until a separate wb_ack.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int QW_BITS   = 64;
    localparam int BEATS     = 4;
    localparam int BEAT_W    = $clog2(BEATS);
    localparam int LINE_BITS = QW_BITS * BEATS;
    localparam int QW_OFS    = $clog2(QW_BITS / 8);
    localparam int OFS_W     = $clog2(LINE_BITS / 8);
    localparam int WAYS      = 4;
    localparam int WAY_W     = $clog2(WAYS);

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_REQ,
        FS_FILL
    } fill_state_e;

    typedef struct packed {
        logic [WAY_W-1:0]  way;
        logic [BEAT_W-1:0] crit;
        logic [BEAT_W-1:0] cnt;
    } fill_ctx_t;

    function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] v);
        first_free = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!v[i]) first_free = WAY_W'(i);
        end
    endfunction
endpackage

// File: rtl/lfc_lfsr.sv
module lfc_lfsr #(
    parameter int W     = 8,
    parameter int OUT_W = 2,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] q;
    logic         fb;

    assign fb  = ^(q & TAPS);
    assign rnd = q[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) q <= W'(1);
        else     q <= {q[W-2:0], fb};
    end
endmodule

// File: rtl/lfc_victim_sel.sv
module lfc_victim_sel import lfc_pkg::*; (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAY_W-1:0] rnd,
    output logic [WAY_W-1:0] way
);
    always_comb begin
        if (&way_valid) way = rnd;
        else            way = first_free(way_valid);
    end
endmodule

// File: rtl/lfc_wb_buf.sv
module lfc_wb_buf import lfc_pkg::*; #(
    parameter int TAG_W = 21,
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [LINE_BITS-1:0] load_line,
    input  logic [TAG_W-1:0]     load_tag,
    input  logic [IDX_W-1:0]     load_idx,
    input  logic [WAY_W-1:0]     load_way,
    input  logic                 ack,
    output logic                 valid,
    output logic [LINE_BITS-1:0] line,
    output logic [TAG_W-1:0]     tag,
    output logic [IDX_W-1:0]     idx,
    output logic [WAY_W-1:0]     way
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else if (ack) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load && !valid) begin
            line <= load_line;
            tag  <= load_tag;
            idx  <= load_idx;
            way  <= load_way;
        end
    end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl import lfc_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int LFSR_W = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
    localparam int LA_W  = ADDR_W - OFS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 miss_valid,
    input  logic [ADDR_W-1:0]    miss_addr,
    input  logic [WAYS-1:0]      way_valid,
    input  logic [WAYS-1:0]      way_dirty,
    input  logic [TAG_W-1:0]     victim_tag,
    input  logic [LINE_BITS-1:0] victim_line,
    output logic                 busy,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [BEAT_W-1:0]    req_qw,
    input  logic                 beat_valid,
    input  logic [QW_BITS-1:0]   beat_data,
    output logic                 beat_ready,
    output logic                 wr_en,
    output logic [WAY_W-1:0]     wr_way,
    output logic [IDX_W-1:0]     wr_index,
    output logic [BEAT_W-1:0]    wr_qw,
    output logic [QW_BITS-1:0]   wr_data,
    output logic                 fwd_valid,
    output logic [QW_BITS-1:0]   fwd_data,
    output logic                 upd_valid,
    output logic [WAY_W-1:0]     upd_way,
    output logic [IDX_W-1:0]     upd_index,
    output logic                 wb_valid,
    output logic [TAG_W-1:0]     wb_tag,
    output logic [IDX_W-1:0]     wb_index,
    output logic [WAY_W-1:0]     wb_way,
    output logic [LINE_BITS-1:0] wb_data,
    input  logic                 wb_ack
);
    fill_state_e      st;
    fill_ctx_t        ctx;
    logic [LA_W-1:0]  line_addr;
    logic [WAY_W-1:0] rnd;
    logic [WAY_W-1:0] pick;
    logic             accept;
    logic             evict;
    logic             last_beat;

    lfc_lfsr #(.W(LFSR_W), .OUT_W(WAY_W), .TAPS(LFSR_TAPS)) u_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    lfc_victim_sel u_sel (
        .way_valid (way_valid),
        .rnd       (rnd),
        .way       (pick)
    );

    assign busy      = (st != FS_IDLE) || wb_valid;
    assign accept    = miss_valid && !busy;
    assign evict     = accept && way_valid[pick] && way_dirty[pick];
    assign last_beat = (ctx.cnt == BEAT_W'(BEATS - 1));

    lfc_wb_buf #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_wb (
        .clk       (clk),
        .rst       (rst),
        .load      (evict),
        .load_line (victim_line),
        .load_tag  (victim_tag),
        .load_idx  (miss_addr[OFS_W +: IDX_W]),
        .load_way  (pick),
        .ack       (wb_ack),
        .valid     (wb_valid),
        .line      (wb_data),
        .tag       (wb_tag),
        .idx       (wb_index),
        .way       (wb_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FS_IDLE;
        end else begin
            unique case (st)
                FS_IDLE: if (accept) st <= FS_REQ;
                FS_REQ:  if (req_ready) st <= FS_FILL;
                FS_FILL: if (beat_valid && last_beat) st <= FS_IDLE;
                default: st <= FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            line_addr <= miss_addr[ADDR_W-1:OFS_W];
            ctx.crit  <= miss_addr[QW_OFS +: BEAT_W];
            ctx.way   <= pick;
            ctx.cnt   <= '0;
        end else if (st == FS_FILL && beat_valid) begin
            ctx.cnt <= ctx.cnt + 1'b1;
        end
    end

    assign req_valid  = (st == FS_REQ);
    assign req_addr   = {line_addr, {OFS_W{1'b0}}};
    assign req_qw     = ctx.crit;
    assign beat_ready = (st == FS_FILL);

    assign wr_en    = (st == FS_FILL) && beat_valid;
    assign wr_way   = ctx.way;
    assign wr_index = line_addr[IDX_W-1:0];
    assign wr_qw    = ctx.crit ^ ctx.cnt;
    assign wr_data  = beat_data;

    assign fwd_valid = wr_en && (ctx.cnt == '0);
    assign fwd_data  = beat_data;

    assign upd_valid = wr_en && last_beat;
    assign upd_way   = ctx.way;
    assign upd_index = line_addr[IDX_W-1:0];
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker import lfc_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy,
    input logic                 miss_valid,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 wr_en,
    input logic [BEAT_W-1:0]    wr_qw,
    input logic [QW_BITS-1:0]   wr_data,
    input logic                 fwd_valid,
    input logic [QW_BITS-1:0]   fwd_data,
    input logic                 upd_valid,
    input logic                 wb_valid,
    input logic                 wb_ack,
    input logic [LINE_BITS-1:0] wb_data,
    input logic [TAG_W-1:0]     wb_tag
);
    logic [BEAT_W-1:0] seen;
    logic [BEAT_W-1:0] first_qw;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (wr_en) begin
            seen <= seen + 1'b1;
            if (seen == '0) first_qw <= wr_qw;
        end
    end

    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    a_r4_interleave: assert property (@(posedge clk) disable iff (rst)
        wr_en && seen != '0 |-> wr_qw == (first_qw ^ seen));

    a_r5_fwd_first: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> wr_en && seen == '0 && fwd_data == wr_data);

    a_r6_upd_on_fourth: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> wr_en && seen == BEAT_W'(BEATS - 1));

    a_r8_wb_hold: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ack |=> wb_valid && $stable(wb_data) && $stable(wb_tag));

    a_r9_wb_busy: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> busy);

    a_r9_accept_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(miss_valid && !busy));
endmodule

bind line_fill_ctrl lfc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk (.*);

// File: tb/line_fill_ctrl_test.sv
module line_fill_ctrl_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic [3:0]   way_valid = '0;
    logic [3:0]   way_dirty = '0;
    logic [20:0]  victim_tag = '0;
    logic [255:0] victim_line = '0;
    logic         busy, req_valid, beat_ready, wr_en, fwd_valid, upd_valid, wb_valid;
    logic         req_ready = 1'b0;
    logic         beat_valid = 1'b0;
    logic [63:0]  beat_data = '0;
    logic         wb_ack = 1'b0;
    logic [31:0]  req_addr;
    logic [1:0]   req_qw, wr_way, wr_qw, upd_way, wb_way;
    logic [5:0]   wr_index, upd_index, wb_index;
    logic [63:0]  wr_data, fwd_data;
    logic [20:0]  wb_tag;
    logic [255:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int tally [4];

    always #4 clk = ~clk;

    line_fill_ctrl uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .way_valid(way_valid), .way_dirty(way_dirty), .victim_tag(victim_tag),
        .victim_line(victim_line), .busy(busy), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_qw(req_qw),
        .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
        .wr_en(wr_en), .wr_way(wr_way), .wr_index(wr_index), .wr_qw(wr_qw),
        .wr_data(wr_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .upd_valid(upd_valid), .upd_way(upd_way), .upd_index(upd_index),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_index(wb_index), .wb_way(wb_way),
        .wb_data(wb_data), .wb_ack(wb_ack)
    );

    task automatic check(input string rq, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic logic [1:0] lowest_zero(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
        return 2'd0;
    endfunction

    // Runs one miss. exp_way is used only when a way is invalid.
    task automatic run_fill(input logic [31:0] addr, input logic [3:0] vm,
                            input logic [3:0] dm, input logic [255:0] vline,
                            input logic [20:0] tg, input bit ack_last);
        logic [1:0] crit;
        logic [1:0] way_seen;
        logic [1:0] exp_way;
        bit         exp_wb;
        crit = addr[4:3];
        exp_way = lowest_zero(vm);
        way_seen = 2'd0;
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = addr; way_valid = vm; way_dirty = dm;
        victim_line = vline; victim_tag = tg;
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
        check("R3", "req_valid", 256'(req_valid), 256'(1'b1));
        check("R3", "req_addr", 256'(req_addr), 256'({addr[31:5], 5'd0}));
        check("R3", "req_qw", 256'(req_qw), 256'(crit));
        check("R9", "busy in fill", 256'(busy), 256'(1'b1));
        if (vm != 4'hF)
            check("R7", "no capture of invalid victim", 256'(wb_valid), 256'(1'b0));
        @(negedge clk);
        check("R3", "req held", 256'(req_valid), 256'(1'b1));
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        #1;
        check("R3", "req dropped", 256'(req_valid), 256'(1'b0));
        for (int b = 0; b < 4; b++) begin
            beat_valid = 1'b1;
            beat_data = {addr, 32'(b) + 32'h55};
            wb_ack = ack_last && (b == 3);
            #1;
            if (b == 0) way_seen = wr_way;
            check("R4", "wr_en", 256'(wr_en), 256'(1'b1));
            check("R4", "wr_qw", 256'(wr_qw), 256'(crit ^ 2'(b)));
            check("R4", "wr_index", 256'(wr_index), 256'(addr[10:5]));
            check("R4", "wr_data", 256'(wr_data), 256'(beat_data));
            check("R5", "fwd_valid", 256'(fwd_valid), 256'(b == 0));
            if (b == 0) check("R5", "fwd_data", 256'(fwd_data), 256'(beat_data));
            check("R6", "upd_valid", 256'(upd_valid), 256'(b == 3));
            if (vm != 4'hF) check("R1", "wr_way", 256'(wr_way), 256'(exp_way));
            else            check("R2", "way stable", 256'(wr_way), 256'(way_seen));
            if (b == 3) begin
                check("R6", "upd_way", 256'(upd_way), 256'(way_seen));
                check("R6", "upd_index", 256'(upd_index), 256'(addr[10:5]));
            end
            @(negedge clk);
        end
        beat_valid = 1'b0;
        wb_ack = 1'b0;
        if (vm == 4'hF) tally[way_seen]++;
        exp_wb = vm[way_seen] && dm[way_seen];
        #1;
        if (exp_wb && !ack_last) begin
            check("R7", "wb_valid", 256'(wb_valid), 256'(1'b1));
            check("R7", "wb_data", wb_data, vline);
            check("R7", "wb_tag", 256'(wb_tag), 256'(tg));
            check("R7", "wb_index", 256'(wb_index), 256'(addr[10:5]));
            check("R7", "wb_way", 256'(wb_way), 256'(way_seen));
            check("R9", "busy while buffer full", 256'(busy), 256'(1'b1));
            miss_valid = 1'b1; miss_addr = addr ^ 32'h40;
            @(negedge clk);
            @(negedge clk);
            miss_valid = 1'b0;
            check("R9", "miss ignored", 256'(req_valid), 256'(1'b0));
            check("R8", "wb held", 256'(wb_valid), 256'(1'b1));
            check("R8", "wb data held", wb_data, vline);
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
            #1;
            check("R8", "wb released", 256'(wb_valid), 256'(1'b0));
        end else begin
            check("R7", "wb_valid after fill", 256'(wb_valid), 256'(1'b0));
        end
        check("R9", "idle after fill", 256'(busy), 256'(1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog expired: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 4; w++) tally[w] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "busy", 256'(busy), 256'(1'b0));
        check("R10", "req_valid", 256'(req_valid), 256'(1'b0));
        check("R10", "wr_en", 256'(wr_en), 256'(1'b0));
        check("R10", "fwd_valid", 256'(fwd_valid), 256'(1'b0));
        check("R10", "upd_valid", 256'(upd_valid), 256'(1'b0));
        check("R10", "wb_valid", 256'(wb_valid), 256'(1'b0));

        // Sweep: every critical quadword against every valid mask.
        for (int c = 0; c < 4; c++) begin
            for (int vm = 0; vm < 16; vm++) begin
                logic [31:0]  a;
                logic [255:0] vl;
                logic [3:0]   dm;
                a  = 32'h9A40_0000 | (32'(vm) << 5) | (32'(c) << 3) | 32'(vm & 7);
                vl = {4{32'hD00D_0000 | 32'(c * 16 + vm), 32'(vm)}};
                dm = (vm == 15) ? (4'b0001 << c) : 4'hF;
                run_fill(a, 4'(vm), dm, vl, 21'(c * 100 + vm), c[0]);
            end
        end

        // Replacement spread over many all-valid misses.
        for (int i = 0; i < 48; i++) begin
            repeat (i % 3) @(negedge clk);
            run_fill(32'h0100_0000 + 32'(i) * 32'h28, 4'hF, 4'h0,
                     256'(i), 21'(i), 1'b0);
        end
        for (int w = 0; w < 4; w++)
            check("R2", $sformatf("way %0d chosen", w), 256'(tally[w] > 0), 256'(1'b1));

        // All-valid, all-dirty: every fill evicts; ack either with last beat or later.
        for (int i = 0; i < 8; i++) begin
            run_fill(32'h7700_0000 + 32'(i) * 32'h68, 4'hF, 4'hF,
                     {8{32'hBEEF_0000 + 32'(i)}}, 21'(i + 7), i[0]);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule